// File: doc/BRIEF.md
# Power Monitor Reset Sequencer

This block converts a digital "supply good" comparator indication into the active-low system reset of a small processor subsystem. It holds reset for as long as the supply is reported low. Once the supply is good again, it keeps reset asserted for a fixed number of clock cycles so that the rail can settle. After a power-fail dip inside normal operation, it runs the same timed sequence as a cold start.

Software can tell why the processor restarted, because every cause restarts execution at the same place. A reset-cause register holds one flag for each source: a power-on flag, an external-pin flag and a watchdog flag. Writing 1 to the power-on flag forces a complete power-on sequence. External and watchdog requests arrive as synchronous request inputs. Each holds reset for at least a minimum pulse length, sets its own flag and clears the power-on flag.

Top module: `pwr_rst_seq`

Register layout (`reg_rdata_o`): bit 0 = external request flag, bit 1 = power-on flag, bit 2 = watchdog flag, bits 7:3 always read 0. A power-on style reset leaves the register at 0x02.

## Requirements
- R1: While the synchronized supply indication is low, `rst_n_o` is low. A supply drop seen at the input drives `rst_n_o` low on the third rising clock edge after it, because of the two synchronizer flops plus the state register.
- R2: After the supply becomes good, `rst_n_o` rises on the (TIMEOUT_CYC+2)-th rising edge after `supply_ok_i` is first sampled high.
- R3: Any low sample of the synchronized supply during the timeout restarts the count from zero. Release then follows R2, measured from the final rise.
- R4: The asynchronous block reset, a supply loss, and a release from either of them all leave the cause register at 0x02 (bit 1 set, all other bits clear).
- R5: While `rst_n_o` is high, a register write with bit 1 of the data set drives `rst_n_o` low on the next edge and loads 0x02. Release follows TIMEOUT_CYC edges later, so the write is seen TIMEOUT_CYC+1 edges before the release.
- R6: A register write with bit 1 clear has no effect: `rst_n_o` stays high and the register value is unchanged.
- R7: With `rst_n_o` high, `ext_req_i` drives `rst_n_o` low on the next edge and sets the register to 0x01 (bit 0 set, bit 1 clear). Reset is released on the PULSE_CYC-th edge with no request after the request drops.
- R8: `wdt_req_i` behaves like R7 but sets bit 2 (0x04). A request that arrives while a request-caused reset is already running ORs its flag into the register.
- R9: Bits 7:3 of the register always read 0. Write data in bits other than bit 1 is ignored.
- R10: Priority, from highest to lowest: supply loss, then software-forced reset, then external and watchdog requests. A forcing write in the same cycle as a request leaves 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block's own flops (cold start) |
| supply_ok_i | input | 1 | Asynchronous comparator output, 1 = supply above threshold |
| ext_req_i | input | 1 | Synchronous external reset request |
| wdt_req_i | input | 1 | Synchronous watchdog reset request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data; only bit 1 acts |
| reg_rdata_o | output | 8 | Reset-cause register read value |
| rst_n_o | output | 1 | Active-low system reset |

## Verification
Every result appears after a fixed number of edges. A supply drop shows on `rst_n_o` after three edges. A supply rise releases reset after TIMEOUT_CYC+2 edges. A forcing write releases after TIMEOUT_CYC+1 edges. A request releases after PULSE_CYC edges following the request's last cycle, and the flags change on the first edge after the triggering input. The bench drives inputs on the falling edge and counts falling edges from the stimulus until the output changes, then compares that count with these formulas. In parallel, a behavioural model with a delay line and countdowns predicts `rst_n_o` and the register value, and the bench compares them on every falling edge.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_PULSE = 2'd1,
    ST_RUN   = 2'd2
  } prs_state_e;

  localparam int FLG_EXT = 0;
  localparam int FLG_POR = 1;
  localparam int FLG_WDT = 2;

  localparam logic [7:0] FLAGS_COLD = 8'h02;

  function automatic logic [7:0] req_flags(input logic ext, input logic wdt);
    logic [7:0] f;
    f = '0;
    f[FLG_EXT] = ext;
    f[FLG_WDT] = wdt;
    return f;
  endfunction

  function automatic logic last_tick(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) == len;
  endfunction

endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/prs_timer.sv
module prs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (adv_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/prs_flags.sv
module prs_flags
  import prs_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       ld_cold_i,
  input  logic       ld_req_i,
  input  logic       or_req_i,
  input  logic       ext_i,
  input  logic       wdt_i,
  output logic [7:0] flags_o
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)        flags_o <= FLAGS_COLD;
    else if (ld_cold_i) flags_o <= FLAGS_COLD;
    else if (ld_req_i)  flags_o <= req_flags(ext_i, wdt_i);
    else if (or_req_i)  flags_o <= flags_o | req_flags(ext_i, wdt_i);
  end
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import prs_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 2500000,
  parameter int unsigned PULSE_CYC   = 16,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       supply_ok_i,
  input  logic       ext_req_i,
  input  logic       wdt_req_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       rst_n_o
);
  localparam int unsigned MAXC = (TIMEOUT_CYC > PULSE_CYC) ? TIMEOUT_CYC : PULSE_CYC;
  localparam int          CW   = $clog2(MAXC + 1);

  prs_state_e     state, state_nx;
  logic           sup_ok_s;
  logic           tmr_clr, tmr_adv, tmr_done;
  logic [CW-1:0]  tmr_cnt;
  int unsigned    tmr_limit;

  // Named events, also observed by the checker
  logic evt_pwr_loss, evt_sw_por, evt_ext, evt_wdt, evt_req;

  prs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d_i    (supply_ok_i),
    .q_o    (sup_ok_s)
  );

  prs_timer #(.W(CW)) u_timer (
    .clk    (clk),
    .arst_n (arst_n),
    .clr_i  (tmr_clr),
    .adv_i  (tmr_adv),
    .cnt_o  (tmr_cnt)
  );

  always_comb begin
    evt_pwr_loss = !sup_ok_s;
    evt_sw_por   = sup_ok_s && (state == ST_RUN) && reg_wr_i && reg_wdata_i[FLG_POR];
    evt_ext      = sup_ok_s && (state != ST_POR) && !evt_sw_por && ext_req_i;
    evt_wdt      = sup_ok_s && (state != ST_POR) && !evt_sw_por && wdt_req_i;
    evt_req      = evt_ext || evt_wdt;
    tmr_limit    = (state == ST_PULSE) ? PULSE_CYC : TIMEOUT_CYC;
    tmr_done     = last_tick(32'(tmr_cnt), tmr_limit);
  end

  always_comb begin
    state_nx = state;
    tmr_clr  = 1'b0;
    tmr_adv  = 1'b0;
    if (evt_pwr_loss) begin
      state_nx = ST_POR;
      tmr_clr  = 1'b1;
    end else begin
      unique case (state)
        ST_POR: begin
          if (tmr_done) begin
            state_nx = ST_RUN;
            tmr_clr  = 1'b1;
          end else begin
            tmr_adv = 1'b1;
          end
        end
        ST_RUN: begin
          if (evt_sw_por) begin
            state_nx = ST_POR;
            tmr_clr  = 1'b1;
          end else if (evt_req) begin
            state_nx = ST_PULSE;
            tmr_clr  = 1'b1;
          end
        end
        ST_PULSE: begin
          if (evt_req) begin
            tmr_clr = 1'b1;
          end else if (tmr_done) begin
            state_nx = ST_RUN;
            tmr_clr  = 1'b1;
          end else begin
            tmr_adv = 1'b1;
          end
        end
        default: begin
          state_nx = ST_POR;
          tmr_clr  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state <= ST_POR;
    else         state <= state_nx;
  end

  prs_flags u_flags (
    .clk       (clk),
    .arst_n    (arst_n),
    .ld_cold_i (evt_pwr_loss || evt_sw_por),
    .ld_req_i  ((state == ST_RUN) && evt_req),
    .or_req_i  (state == ST_PULSE),
    .ext_i     (evt_ext),
    .wdt_i     (evt_wdt),
    .flags_o   (reg_rdata_o)
  );

  assign rst_n_o = (state == ST_RUN);
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int unsigned TIMEOUT_CYC = 2500000,
  parameter int unsigned PULSE_CYC   = 16
) (
  input logic       clk,
  input logic       arst_n,
  input logic       rst_n_o,
  input logic [7:0] reg_rdata_o,
  input logic       sup_ok_s,
  input logic       evt_sw_por,
  input logic       evt_ext,
  input logic       evt_wdt
);
  logic [31:0] ok_run, low_len;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ok_run  <= '0;
      low_len <= '0;
    end else begin
      ok_run  <= !sup_ok_s ? '0 : ((ok_run  == 32'hFFFF_FFFF) ? ok_run  : ok_run  + 1);
      low_len <= rst_n_o   ? '0 : ((low_len == 32'hFFFF_FFFF) ? low_len : low_len + 1);
    end
  end

  AST_HOLD_ON_LOSS: assert property (@(posedge clk) disable iff (!arst_n)
    !sup_ok_s |=> !rst_n_o); // R1
  AST_TIMEOUT_LEN: assert property (@(posedge clk) disable iff (!arst_n)
    ($rose(rst_n_o) && reg_rdata_o[1]) |-> (ok_run >= TIMEOUT_CYC)); // R2
  AST_COLD_FLAGS: assert property (@(posedge clk) disable iff (!arst_n)
    !sup_ok_s |=> (reg_rdata_o == 8'h02)); // R4
  AST_SW_FORCE: assert property (@(posedge clk) disable iff (!arst_n)
    evt_sw_por |=> (!rst_n_o && reg_rdata_o == 8'h02)); // R5
  AST_EXT_FLAG: assert property (@(posedge clk) disable iff (!arst_n)
    evt_ext |=> (!rst_n_o && reg_rdata_o[0] && !reg_rdata_o[1])); // R7
  AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    ($rose(rst_n_o) && !reg_rdata_o[1]) |-> (low_len >= PULSE_CYC)); // R7
  AST_WDT_FLAG: assert property (@(posedge clk) disable iff (!arst_n)
    evt_wdt |=> (!rst_n_o && reg_rdata_o[2] && !reg_rdata_o[1])); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    reg_rdata_o[7:3] == 5'd0); // R9
endmodule

bind pwr_rst_seq prs_checker #(
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .PULSE_CYC   (PULSE_CYC)
) u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .rst_n_o     (rst_n_o),
  .reg_rdata_o (reg_rdata_o),
  .sup_ok_s    (sup_ok_s),
  .evt_sw_por  (evt_sw_por),
  .evt_ext     (evt_ext),
  .evt_wdt     (evt_wdt)
);

// File: tb/pwr_rst_seq_tb.sv
module pwr_rst_seq_tb;
  localparam int T = 20;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       supply_ok_i = 1'b0;
  logic       ext_req_i = 1'b0;
  logic       wdt_req_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       rst_n_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_req = "R4";

  pwr_rst_seq #(.TIMEOUT_CYC(T), .PULSE_CYC(P)) u_dut (
    .clk(clk), .arst_n(arst_n), .supply_ok_i(supply_ok_i),
    .ext_req_i(ext_req_i), .wdt_req_i(wdt_req_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .rst_n_o(rst_n_o)
  );

  always #5 clk = ~clk;

  // Behavioural reference: supply delay line, a held flag, a countdown
  bit        d0, d1;
  bit        m_held;
  bit        m_cold;
  int        m_left;
  logic [7:0] m_flags;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      d0 = 0; d1 = 0; m_held = 1; m_cold = 1; m_left = T; m_flags = 8'h02;
    end else begin
      if (!d1) begin
        m_held = 1; m_cold = 1; m_left = T; m_flags = 8'h02;
      end else if (m_held && m_cold) begin
        m_left--;
        if (m_left == 0) m_held = 0;
      end else if (!m_held && reg_wr_i && reg_wdata_i[1]) begin
        m_held = 1; m_cold = 1; m_left = T; m_flags = 8'h02;
      end else if (!m_held && (ext_req_i || wdt_req_i)) begin
        m_held = 1; m_cold = 0; m_left = P;
        m_flags = {5'd0, wdt_req_i, 1'b0, ext_req_i};
      end else if (m_held) begin
        m_flags = m_flags | {5'd0, wdt_req_i, 1'b0, ext_req_i};
        if (ext_req_i || wdt_req_i) m_left = P;
        else begin
          m_left--;
          if (m_left == 0) m_held = 0;
        end
      end
      d1 = d0;
      d0 = supply_ok_i;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (arst_n) begin
      chk(cur_req, "model rst_n", int'(rst_n_o), int'(!m_held));
      chk(cur_req, "model flags", int'(reg_rdata_o), int'(m_flags));
    end
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic edges_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (rst_n_o !== lvl && n < 1000);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R4", "reset rst_n", int'(rst_n_o), 0);
    chk("R4", "reset flags", int'(reg_rdata_o), 8'h02);
    arst_n = 1'b1;
    cur_req = "R1";
    repeat (10) @(negedge clk);
    chk("R1", "held with supply low", int'(rst_n_o), 0);

    cur_req = "R2";
    supply_ok_i = 1'b1;
    edges_until(1'b1, n);
    chk("R2", "cold release edges", n, T + 2);
    chk("R4", "flags after cold", int'(reg_rdata_o), 8'h02);

    cur_req = "R1";
    repeat (3) @(negedge clk);
    supply_ok_i = 1'b0;
    edges_until(1'b0, n);
    chk("R1", "loss to reset edges", n, 3);
    supply_ok_i = 1'b1;
    cur_req = "R3";
    repeat (5) @(negedge clk);
    supply_ok_i = 1'b0;
    @(negedge clk);
    supply_ok_i = 1'b1;
    edges_until(1'b1, n);
    chk("R3", "glitch restart edges", n, T + 2);
    chk("R4", "flags after power fail", int'(reg_rdata_o), 8'h02);

    cur_req = "R7";
    repeat (2) @(negedge clk);
    ext_req_i = 1'b1;
    @(negedge clk);
    chk("R7", "ext asserts reset", int'(rst_n_o), 0);
    chk("R7", "ext flags", int'(reg_rdata_o), 8'h01);
    repeat (2) @(negedge clk);
    ext_req_i = 1'b0;
    edges_until(1'b1, n);
    chk("R7", "ext release edges", n, P);

    cur_req = "R5";
    repeat (2) @(negedge clk);
    reg_wr_i = 1'b1; reg_wdata_i = 8'h02;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
    chk("R5", "sw force asserts", int'(rst_n_o), 0);
    chk("R5", "sw force flags", int'(reg_rdata_o), 8'h02);
    edges_until(1'b1, n);
    chk("R5", "sw force release edges", n, T);

    cur_req = "R8";
    repeat (2) @(negedge clk);
    wdt_req_i = 1'b1;
    @(negedge clk);
    wdt_req_i = 1'b0;
    chk("R8", "wdt flags", int'(reg_rdata_o), 8'h04);
    @(negedge clk);
    ext_req_i = 1'b1;
    @(negedge clk);
    ext_req_i = 1'b0;
    edges_until(1'b1, n);
    chk("R8", "pulse release after late ext", n, P);
    chk("R8", "or-ed flags", int'(reg_rdata_o), 8'h05);

    cur_req = "R6";
    reg_wr_i = 1'b1; reg_wdata_i = 8'h00;
    @(negedge clk);
    reg_wdata_i = 8'hFD;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
    repeat (2) @(negedge clk);
    chk("R6", "write of 0 keeps run", int'(rst_n_o), 1);
    chk("R6", "write of 0 keeps flags", int'(reg_rdata_o), 8'h05);
    chk("R9", "upper bits zero", int'(reg_rdata_o[7:3]), 0);

    cur_req = "R10";
    reg_wr_i = 1'b1; reg_wdata_i = 8'h02; ext_req_i = 1'b1; wdt_req_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00; ext_req_i = 1'b0; wdt_req_i = 1'b0;
    chk("R10", "write beats request flags", int'(reg_rdata_o), 8'h02);
    edges_until(1'b1, n);
    chk("R10", "write beats request release", n, T);

    ext_req_i = 1'b1;
    supply_ok_i = 1'b0;
    repeat (4) @(negedge clk);
    ext_req_i = 1'b0;
    chk("R10", "loss beats request flags", int'(reg_rdata_o), 8'h02);
    supply_ok_i = 1'b1;
    edges_until(1'b1, n);
    chk("R10", "loss release edges", n, T + 2);
    chk("R4", "final flags", int'(reg_rdata_o), 8'h02);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule